// File: doc/BRIEF.md
# Locality Ownership Arbiter

Five numbered requesters (localities 0 to 4) share one command interface. At most one of them owns it at a time. Each locality has its own one-byte access register. The locality of an access comes from a 3-bit field in the address, just above the register offset. By writing its access register, a locality can:

- ask for ownership,
- give ownership up,
- take ownership by force (a seize), or
- clear the flag that says it lost ownership to a seize.

Reading the register returns the locality's own flags and a live "someone else is waiting" bit.

Handing ownership over can cut off a command that is still running. When `cmd_busy` is high at that moment, the arbiter does not switch at once. It raises `abort_req`, reports the outgoing owner on `abort_from` and the incoming owner on `abort_to`, and waits for `abort_done`. Every real change of owner to a valid locality produces a one-cycle `loc_changed` pulse. Locality 4 is reserved for hardware: its writes count only while `hw_access` is high.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface: `active_loc` reads 7, `abort_req` is 0, and every access register reads 0x80.
- R2: The access byte read one cycle after `rd_en` holds these bits:
  - bit 7: always 1
  - bit 5: this locality is the owner
  - bit 4: lost ownership to a seize
  - bit 3: always 0
  - bit 1: ownership requested
  - bit 0: the inverse of `established`
- R3: Bit 2 of the read byte is set exactly when some other locality has its request bit set.
- R4: Writing bit 1 (request) gives ownership in the same write when nobody owns the interface. Otherwise it only latches the request. The owner's own request bit is never set.
- R5: The owner releases by writing bit 5. The highest-numbered requester becomes the next owner. If nobody is waiting, `active_loc` goes to 7.
- R6: A write of bit 5 by a locality that is not the owner only clears that locality's own request bit.
- R7: Bit 3 (seize) is accepted only when:
  - nobody owns the interface, or the writer outranks the owner;
  - the writer has no seize pending of its own; and
  - no higher locality has a seize pending.

  Acceptance clears the pending seizes of all lower localities. Bits 1 and 5 of a seize write are ignored.
- R8: A handover by seize sets bit 4 on the old owner and leaves its request bit alone. A normal handover clears the old owner's request bit. The new owner's request and seize bits clear.
- R9: Writing bit 4 clears the writer's seized flag.
- R10: `loc_changed` pulses for one cycle only when the owner changes to a valid locality. Releasing to nobody does not pulse it.
- R11: If `cmd_busy` is high when ownership must move, the owner stays put and `abort_req` rises with `abort_from` and `abort_to`. The move takes place on `abort_done`.
- R12: A write to locality 4 while `hw_access` is low has no effect.
- R13: The locality is taken from address bits [14:12]. Only offset 0 with a locality below 5 and bit 15 clear is the access register. Such other addresses read 0xFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write address (locality field + offset) |
| wr_data | input | 8 | Write byte |
| hw_access | input | 1 | Qualifier that allows writes to locality 4 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read byte |
| established | input | 1 | Established state, shown inverted in bit 0 |
| cmd_busy | input | 1 | A command is executing |
| abort_done | input | 1 | Pending abort has finished |
| active_loc | output | 3 | Current owner, 7 when none |
| loc_changed | output | 1 | One-cycle pulse on an owner change |
| abort_req | output | 1 | Abort pending |
| abort_from | output | 3 | Locality being aborted |
| abort_to | output | 3 | Locality that takes over after the abort |

## Verification
A corrupted request or seize vector shows in the very next access-register read: bit 2 or bit 1 comes back wrong for some locality. It also shows on the next release or seize, because the owner chosen on `active_loc` differs. A wrong owner register is visible on `active_loc` and in bit 5 straight away. A lost or spurious handover shows as a missing or extra `loc_changed` pulse in the cycle after the write or after `abort_done`. A stale abort target shows on `abort_to` while `abort_req` is high.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int LOC_W = 3;
  localparam int SLOTS = 1 << LOC_W;
  localparam logic [LOC_W-1:0] NO_LOC = '1;

  // access byte bit positions
  localparam int B_VALID  = 7;
  localparam int B_OWNER  = 5;
  localparam int B_LOST   = 4;
  localparam int B_SEIZE  = 3;
  localparam int B_WAIT   = 2;
  localparam int B_REQ    = 1;
  localparam int B_EST    = 0;

  localparam logic [7:0] NOT_MAPPED = 8'hFF;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode
  import loc_arb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int NUM_LOC   = 5,
  parameter int ACC_OFS   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOC_W-1:0]  loc,
  output logic              hit
);
  localparam int TOP_LSB = LOC_SHIFT + LOC_W;

  logic [LOC_SHIFT-1:0]      ofs;
  logic [ADDR_W-TOP_LSB-1:0] upper;

  always_comb begin
    loc   = addr[LOC_SHIFT +: LOC_W];
    ofs   = addr[LOC_SHIFT-1:0];
    upper = addr[ADDR_W-1:TOP_LSB];
    hit   = (ofs == LOC_SHIFT'(ACC_OFS)) && (upper == '0) &&
            (int'(loc) < NUM_LOC);
  end
endmodule

// File: rtl/loc_pick_highest.sv
module loc_pick_highest
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic [SLOTS-1:0] vec,
  output logic [LOC_W-1:0] idx
);
  logic [LOC_W-1:0] cand [NUM_LOC+1];

  assign cand[0] = NO_LOC;

  // ripple from the lowest slot upward so the highest set slot wins
  for (genvar g = 0; g < NUM_LOC; g++) begin : g_stage
    assign cand[g+1] = vec[g] ? LOC_W'(g) : cand[g];
  end

  assign idx = cand[NUM_LOC];
endmodule

// File: rtl/loc_readback.sv
module loc_readback
  import loc_arb_pkg::*;
(
  input  logic [LOC_W-1:0] loc,
  input  logic             hit,
  input  logic [LOC_W-1:0] owner,
  input  logic [SLOTS-1:0] req,
  input  logic [SLOTS-1:0] lost,
  input  logic             established,
  output logic [7:0]       byte_out
);
  logic [SLOTS-1:0] others;

  always_comb begin
    others   = req & ~(SLOTS'(1) << loc);
    byte_out = '0;
    byte_out[B_VALID] = 1'b1;
    byte_out[B_OWNER] = (owner == loc);
    byte_out[B_LOST]  = lost[loc];
    byte_out[B_SEIZE] = 1'b0;
    byte_out[B_WAIT]  = |others;
    byte_out[B_REQ]   = req[loc];
    byte_out[B_EST]   = ~established;
    if (!hit) byte_out = NOT_MAPPED;
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int NUM_LOC   = 5,
  parameter int ACC_OFS   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hw_access,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              established,
  input  logic              cmd_busy,
  input  logic              abort_done,
  output logic [LOC_W-1:0]  active_loc,
  output logic              loc_changed,
  output logic              abort_req,
  output logic [LOC_W-1:0]  abort_from,
  output logic [LOC_W-1:0]  abort_to
);
  localparam logic [LOC_W-1:0] HW_LOC = LOC_W'(NUM_LOC - 1);

  typedef struct packed {
    logic [LOC_W-1:0] act;
    logic [LOC_W-1:0] nxt;
    logic [LOC_W-1:0] abt;
    logic [SLOTS-1:0] ru;
    logic [SLOTS-1:0] sz;
    logic [SLOTS-1:0] bs;
    logic             ev;
  } st_t;

  st_t q, s1, s2;

  // ---------------- address decode ----------------
  logic [LOC_W-1:0] wr_loc, rd_loc;
  logic             wr_hit, rd_hit;

  loc_addr_decode #(.ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT),
                    .NUM_LOC(NUM_LOC), .ACC_OFS(ACC_OFS))
    u_wdec (.addr(wr_addr), .loc(wr_loc), .hit(wr_hit));

  loc_addr_decode #(.ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT),
                    .NUM_LOC(NUM_LOC), .ACC_OFS(ACC_OFS))
    u_rdec (.addr(rd_addr), .loc(rd_loc), .hit(rd_hit));

  logic wr_ok;
  assign wr_ok = wr_en && wr_hit && !(wr_loc == HW_LOC && !hw_access);

  // only bits 5, 4, 3 and 1 of a write carry meaning
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[7:6], wr_data[2], wr_data[0]};

  // ---------------- ownership move ----------------
  function automatic st_t hand_over(st_t s, logic [LOC_W-1:0] n);
    st_t r;
    logic chg, by_seize;
    r   = s;
    chg = (s.act != n);
    by_seize = (n != NO_LOC) && s.sz[n];
    if (chg && s.act != NO_LOC) begin
      if (by_seize) r.bs[s.act] = 1'b1;
      else          r.ru[s.act] = 1'b0;
    end
    r.act = n;
    if (n != NO_LOC) begin
      r.ru[n] = 1'b0;
      r.sz[n] = 1'b0;
    end
    if (chg && n != NO_LOC) r.ev = 1'b1;
    return r;
  endfunction

  function automatic st_t start_move(st_t s, logic [LOC_W-1:0] from,
                                     logic [LOC_W-1:0] to, logic busy);
    st_t r;
    r = s;
    if (busy) begin
      r.nxt = to;
      r.abt = from;
    end else begin
      r = hand_over(s, to);
      r.nxt = NO_LOC;
      r.abt = NO_LOC;
    end
    return r;
  endfunction

  // stage 1: finish a pending abort
  always_comb begin
    s1    = q;
    s1.ev = 1'b0;
    if (abort_done && q.nxt != NO_LOC) begin
      s1     = hand_over(s1, q.nxt);
      s1.nxt = NO_LOC;
      s1.abt = NO_LOC;
    end
  end

  logic [LOC_W-1:0] pick;
  loc_pick_highest #(.NUM_LOC(NUM_LOC)) u_pick (.vec(s1.ru), .idx(pick));

  // stage 2: apply the access write
  logic [7:0]       wv;
  logic [LOC_W-1:0] na;
  logic             set_new, seize_ok;
  logic [SLOTS-1:0] hi_mask, lo_mask;

  always_comb begin
    s2      = s1;
    wv      = wr_data;
    na      = s1.act;
    set_new = 1'b1;
    hi_mask = '0;
    lo_mask = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (k > int'(wr_loc)) hi_mask[k] = 1'b1;
      if (k < int'(wr_loc)) lo_mask[k] = 1'b1;
    end
    if (wv[B_SEIZE]) begin
      wv[B_REQ]   = 1'b0;
      wv[B_OWNER] = 1'b0;
    end
    seize_ok = 1'b0;
    if (wr_ok) begin
      if (wv[B_OWNER]) begin
        if (s2.act == wr_loc) begin
          if (pick != NO_LOC) begin
            set_new = 1'b0;
            s2 = start_move(s2, wr_loc, pick, cmd_busy);
          end else begin
            na = NO_LOC;
          end
        end else begin
          s2.ru[wr_loc] = 1'b0;
        end
      end
      if (wv[B_LOST]) s2.bs[wr_loc] = 1'b0;
      if (wv[B_SEIZE]) begin
        seize_ok = (s2.act == NO_LOC || wr_loc > s2.act) &&
                   !s2.sz[wr_loc] && !(|(s2.sz & hi_mask));
        if (seize_ok) begin
          s2.sz = s2.sz & ~lo_mask;
          s2.sz[wr_loc] = 1'b1;
          set_new = 1'b0;
          s2 = start_move(s2, s2.act, wr_loc, cmd_busy);
        end
      end
      if (wv[B_REQ] && s2.act != wr_loc) begin
        if (s2.act != NO_LOC) s2.ru[wr_loc] = 1'b1;
        else                  na = wr_loc;
      end
      if (set_new) s2 = hand_over(s2, na);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q.act <= NO_LOC;
      q.nxt <= NO_LOC;
      q.abt <= NO_LOC;
      q.ru  <= '0;
      q.sz  <= '0;
      q.bs  <= '0;
      q.ev  <= 1'b0;
    end else begin
      q <= s2;
    end
  end

  // ---------------- readback ----------------
  logic [7:0] rb;
  loc_readback u_rb (
    .loc(rd_loc), .hit(rd_hit), .owner(q.act), .req(q.ru), .lost(q.bs),
    .established(established), .byte_out(rb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rb;
    end
  end

  assign active_loc  = q.act;
  assign loc_changed = q.ev;
  assign abort_req   = (q.nxt != NO_LOC);
  assign abort_from  = q.abt;
  assign abort_to    = q.nxt;

  // ---------------- assertions ----------------
  a_r1_owner_legal: assert property (@(posedge clk) disable iff (rst)
    (int'(active_loc) < NUM_LOC) || (active_loc == NO_LOC));

  a_r4_owner_no_request: assert property (@(posedge clk) disable iff (rst)
    (active_loc != NO_LOC) |-> !q.ru[active_loc]);

  a_r7_single_seize: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q.sz));

  a_r10_real_change: assert property (@(posedge clk) disable iff (rst)
    loc_changed |-> (active_loc != $past(active_loc)) && (active_loc != NO_LOC));

  a_r11_abort_target: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> (abort_to != active_loc) && (int'(abort_to) < NUM_LOC));

  a_r12_hw_gate: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit && wr_loc == HW_LOC && !hw_access && !abort_done)
      |=> $stable(active_loc) && $stable(q.ru) && $stable(q.sz) && $stable(q.bs));
endmodule

// File: tb/loc_arbiter_bench.sv
`timescale 1ns/1ps
module loc_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hw_access = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        established = 1'b1;
  logic        cmd_busy = 1'b0;
  logic        abort_done = 1'b0;
  logic [2:0]  active_loc;
  logic        loc_changed;
  logic        abort_req;
  logic [2:0]  abort_from;
  logic [2:0]  abort_to;

  always #10 clk = ~clk;

  loc_arbiter u_loc_arbiter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_access(hw_access), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .established(established),
    .cmd_busy(cmd_busy), .abort_done(abort_done), .active_loc(active_loc),
    .loc_changed(loc_changed), .abort_req(abort_req),
    .abort_from(abort_from), .abort_to(abort_to)
  );

  int n_checks = 0;
  int n_fail = 0;
  int ev_cnt = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: counts owner-change pulses and scores read results
  always @(negedge clk) begin
    if (!rst && loc_changed) ev_cnt++;
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("unexpected read data", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic wr(input int loc, input int ofs, input logic [7:0] d,
                    input logic hw = 1'b0);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = {1'b0, 3'(loc), 12'(ofs)};
    wr_data = d;
    hw_access = hw;
    @(negedge clk);
    wr_en = 1'b0;
    hw_access = 1'b0;
  endtask

  task automatic rd(input int loc, input int ofs, input logic [7:0] exp,
                    input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = {1'b0, 3'(loc), 12'(ofs)};
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    abort_done = 1'b1;
    @(negedge clk);
    abort_done = 1'b0;
  endtask

  task automatic chk_ev(input int exp, input string tag);
    @(negedge clk);
    check(tag, ev_cnt, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 owner after reset", active_loc, 7);
    check("R1 abort after reset", abort_req, 0);
    rd(0, 0, 8'h80, "R1 reset readback loc0");

    // R13 decode: wrong offset and locality 5 ignored / unmapped
    wr(0, 12'h004, 8'h02);
    check("R13 wrong offset write ignored", active_loc, 7);
    wr(5, 0, 8'h02);
    check("R13 locality 5 write ignored", active_loc, 7);
    rd(0, 12'h008, 8'hFF, "R13 unmapped offset reads FF");
    rd(6, 0, 8'hFF, "R13 locality 6 reads FF");

    // R4 immediate grant
    wr(0, 0, 8'h02);
    check("R4 grant when idle", active_loc, 0);
    chk_ev(1, "R10 event on first grant");
    rd(0, 0, 8'hA0, "R2 owner readback");

    // R4 latch, R3 pending
    wr(2, 0, 8'h02);
    check("R4 request latched, owner kept", active_loc, 0);
    rd(2, 0, 8'h82, "R4 loc2 request bit");
    rd(0, 0, 8'hA4, "R3 owner sees waiting");
    wr(1, 0, 8'h02);
    rd(1, 0, 8'h86, "R3 loc1 sees loc2 waiting");

    // R6 non-owner release
    wr(1, 0, 8'h20);
    check("R6 owner unchanged", active_loc, 0);
    rd(1, 0, 8'h84, "R6 loc1 request cleared");

    // R5 release to highest requester
    wr(0, 0, 8'h20);
    check("R5 next owner is loc2", active_loc, 2);
    chk_ev(2, "R10 event on release handover");
    rd(2, 0, 8'hA0, "R8 new owner request cleared");
    rd(0, 0, 8'h80, "R8 old owner cleared");

    // R12 hardware gate
    wr(4, 0, 8'h08, 1'b0);
    check("R12 loc4 seize without hw dropped", active_loc, 2);
    rd(4, 0, 8'h80, "R12 loc4 readback unchanged");

    // R7 lower seize refused
    wr(1, 0, 8'h08);
    check("R7 lower seize refused", active_loc, 2);

    // R8 seize handover
    wr(0, 0, 8'h02);
    rd(0, 0, 8'h82, "R4 loc0 request latched");
    wr(3, 0, 8'h0A);
    check("R7 higher seize accepted", active_loc, 3);
    chk_ev(3, "R10 event on seize");
    rd(2, 0, 8'h94, "R8 old owner seized flag");
    rd(3, 0, 8'hA4, "R7 request bit of seize write ignored");
    rd(0, 0, 8'h82, "R8 bystander request kept");

    // R9 clear seized flag
    wr(2, 0, 8'h10);
    rd(2, 0, 8'h84, "R9 seized flag cleared");

    // R11 abort on busy release
    cmd_busy = 1'b1;
    wr(3, 0, 8'h20);
    check("R11 owner held during abort", active_loc, 3);
    check("R11 abort raised", abort_req, 1);
    check("R11 abort from", abort_from, 3);
    check("R11 abort to", abort_to, 0);
    pulse_done();
    check("R11 move on done", active_loc, 0);
    check("R11 abort cleared", abort_req, 0);
    chk_ev(4, "R10 event after abort");
    rd(0, 0, 8'hA0, "R11 new owner readback");
    rd(3, 0, 8'h80, "R11 old owner readback");

    // R7 pending seize priority under busy
    wr(3, 0, 8'h08);
    check("R7 seize pending target", abort_to, 3);
    wr(2, 0, 8'h08);
    check("R7 seize under higher pending refused", abort_to, 3);
    wr(4, 0, 8'h08, 1'b1);
    check("R7 top seize overrides", abort_to, 4);
    check("R7 abort from owner", abort_from, 0);
    rd(4, 0, 8'h80, "R2 seize bit reads 0");
    pulse_done();
    check("R12 hw locality owns", active_loc, 4);
    chk_ev(5, "R10 event on hw seize");
    rd(0, 0, 8'h90, "R8 seized old owner");
    rd(4, 0, 8'hA0, "R8 seize bit cleared on owner");

    // R10 release to nobody
    cmd_busy = 1'b0;
    wr(4, 0, 8'h20, 1'b1);
    check("R5 release to none", active_loc, 7);
    chk_ev(5, "R10 no event on release to none");

    // R2 established bit
    established = 1'b0;
    rd(1, 0, 8'h81, "R2 established bit inverted");

    wr(1, 0, 8'h02);
    check("R4 regrant when idle", active_loc, 1);
    chk_ev(6, "R10 event on regrant");

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule